// File: doc/BRIEF.md
# Paired Good/Faulty Gate Evaluator

This block evaluates one logic gate on signals that describe two circuits at once. One is the fault-free circuit and the other is a copy of it that carries an injected fault. Each operand is a symbol from a nine-value alphabet. A symbol packs a good-circuit component and a faulty-circuit component, and each component is 0, 1 or unknown. The gate is applied to the good components and to the faulty components separately. The two results are then folded back into a single symbol. Because of this, one evaluation pass tells a test-generation or fault-simulation engine what both circuits do.

Next to the result symbol, the block reports whether the result carries a visible fault effect (both components known and different). It also reports whether the result is free of unknowns. A parameter chooses between purely combinational outputs and a single register stage with a clock enable.

Top module: `nine_val_eval`

## Requirements
- R1: Symbol codes on `op_a`, `op_b` and `res` (good/faulty): 0 = 0/0, 1 = 1/1, 2 = 1/0 (fault effect D), 3 = 0/1 (inverted fault effect), 4 = X/X, 5 = 0/X, 6 = 1/X, 7 = X/0, 8 = X/1. `res` never carries a code above 8.
- R2: With `gate_sel` 0 = AND, 1 = OR, 2 = NAND, 3 = NOR, the gate is applied to each component on its own using three-valued logic. A controlling input (0 for AND/NAND, 1 for OR/NOR) fixes that component even when the other input is X.
- R3: With `gate_sel` 4 = XOR or 5 = XNOR, a component is X whenever either input has X in it. Otherwise it is the exclusive-or of the inputs, inverted for XNOR.
- R4: With `gate_sel` 6 = NOT or 7 = BUF, `op_b` has no effect. NOT inverts each component, so 2 becomes 3 and 5 becomes 6. BUF returns `op_a` unchanged.
- R5: `fault_fx` is 1 exactly when `res` is 2 or 3.
- R6: `known` is 1 exactly when `res` is 0, 1, 2 or 3.
- R7: Operand codes 9 to 15 are treated as X/X.
- R8: With `REG_OUT` = 1, the outputs show the result of the operands that were present at the previous rising clock edge at which `en` was 1. While `en` is 0 the outputs hold. With `REG_OUT` = 0, the outputs follow the inputs with no clock.
- R9: With `REG_OUT` = 1, a low `rst_n` forces `res` = 4 and `fault_fx` = `known` = 0 at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Load enable for the output register |
| op_a | input | 4 | First operand symbol |
| op_b | input | 4 | Second operand symbol (ignored by NOT/BUF) |
| gate_sel | input | 3 | Gate type select |
| res | output | 4 | Result symbol |
| fault_fx | output | 1 | Result is a fault effect (code 2 or 3) |
| known | output | 1 | Result has no unknown component |

## Verification
The bench builds two copies of the block. One uses `REG_OUT` = 1 and the other uses `REG_OUT` = 0, both driven by the same stimulus. This puts the one-cycle load path, the enable hold and the asynchronous reset within reach alongside the combinational datapath. Every gate type is swept over all 81 operand pairs on both copies. Unused operand codes 9 to 15 are added to show that they collapse to X/X.

// File: rtl/nv_pkg.sv
`timescale 1ns/1ps
package nv_pkg;
  localparam int SYM_W  = 4;
  localparam int TRIT_W = 2;
  localparam int SEL_W  = 3;
  localparam int NUM_SYM = 9;

  typedef logic [SYM_W-1:0]  sym_t;
  typedef logic [TRIT_W-1:0] trit_t;

  // three-valued component: 00 = 0, 01 = 1, 1x = unknown
  localparam trit_t T0 = 2'b00;
  localparam trit_t T1 = 2'b01;
  localparam trit_t TX = 2'b10;

  localparam sym_t S_ZERO = 4'd0;
  localparam sym_t S_ONE  = 4'd1;
  localparam sym_t S_D    = 4'd2;
  localparam sym_t S_DB   = 4'd3;
  localparam sym_t S_XX   = 4'd4;
  localparam sym_t S_G0   = 4'd5;
  localparam sym_t S_G1   = 4'd6;
  localparam sym_t S_F0   = 4'd7;
  localparam sym_t S_F1   = 4'd8;

  typedef enum logic [SEL_W-1:0] {
    GT_AND  = 3'd0,
    GT_OR   = 3'd1,
    GT_NAND = 3'd2,
    GT_NOR  = 3'd3,
    GT_XOR  = 3'd4,
    GT_XNOR = 3'd5,
    GT_NOT  = 3'd6,
    GT_BUF  = 3'd7
  } gate_op_e;
endpackage

// File: rtl/nv_sym_split.sv
`timescale 1ns/1ps
module nv_sym_split
  import nv_pkg::*;
(
  input  sym_t  sym,
  output trit_t good,
  output trit_t bad
);
  always_comb begin
    unique case (sym)
      S_ZERO:  begin good = T0; bad = T0; end
      S_ONE:   begin good = T1; bad = T1; end
      S_D:     begin good = T1; bad = T0; end
      S_DB:    begin good = T0; bad = T1; end
      S_G0:    begin good = T0; bad = TX; end
      S_G1:    begin good = T1; bad = TX; end
      S_F0:    begin good = TX; bad = T0; end
      S_F1:    begin good = TX; bad = T1; end
      default: begin good = TX; bad = TX; end  // X/X and unused codes
    endcase
  end
endmodule

// File: rtl/nv_trit_gate.sv
`timescale 1ns/1ps
module nv_trit_gate
  import nv_pkg::*;
(
  input  gate_op_e op,
  input  trit_t    a,
  input  trit_t    b,
  output trit_t    y
);
  logic a_x, b_x, a_0, b_0, a_1, b_1;
  trit_t and_v, or_v, xor_v;

  function automatic trit_t t_inv(input trit_t t);
    return t[1] ? TX : {1'b0, ~t[0]};
  endfunction

  always_comb begin
    a_x = a[1];
    b_x = b[1];
    a_0 = ~a_x & ~a[0];
    b_0 = ~b_x & ~b[0];
    a_1 = ~a_x &  a[0];
    b_1 = ~b_x &  b[0];

    if (a_0 | b_0)      and_v = T0;
    else if (a_1 & b_1) and_v = T1;
    else                and_v = TX;

    if (a_1 | b_1)      or_v = T1;
    else if (a_0 & b_0) or_v = T0;
    else                or_v = TX;

    if (a_x | b_x)      xor_v = TX;
    else                xor_v = {1'b0, a[0] ^ b[0]};

    unique case (op)
      GT_AND:  y = and_v;
      GT_OR:   y = or_v;
      GT_NAND: y = t_inv(and_v);
      GT_NOR:  y = t_inv(or_v);
      GT_XOR:  y = xor_v;
      GT_XNOR: y = t_inv(xor_v);
      GT_NOT:  y = t_inv(a);
      default: y = a_x ? TX : a;
    endcase
  end
endmodule

// File: rtl/nv_sym_join.sv
`timescale 1ns/1ps
module nv_sym_join
  import nv_pkg::*;
(
  input  trit_t good,
  input  trit_t bad,
  output sym_t  sym,
  output logic  fx,
  output logic  kn
);
  always_comb begin
    unique casez ({good, bad})
      4'b0000: sym = S_ZERO;
      4'b0101: sym = S_ONE;
      4'b0100: sym = S_D;
      4'b0001: sym = S_DB;
      4'b001?: sym = S_G0;
      4'b011?: sym = S_G1;
      4'b1?00: sym = S_F0;
      4'b1?01: sym = S_F1;
      default: sym = S_XX;
    endcase
    kn = ~good[1] & ~bad[1];
    fx = kn & (good[0] ^ bad[0]);
  end
endmodule

// File: rtl/nine_val_eval.sv
`timescale 1ns/1ps
module nine_val_eval
  import nv_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [3:0] op_a,
  input  logic [3:0] op_b,
  input  logic [2:0] gate_sel,
  output logic [3:0] res,
  output logic       fault_fx,
  output logic       known
);
  localparam int NUM_OPS  = 2;  // operand a, operand b
  localparam int NUM_MACH = 2;  // 0 = good, 1 = faulty

  trit_t    comp [NUM_OPS][NUM_MACH];
  trit_t    outc [NUM_MACH];
  sym_t     ops  [NUM_OPS];
  gate_op_e op;
  sym_t     sym_c;
  logic     fx_c, kn_c;

  assign ops[0] = op_a;
  assign ops[1] = op_b;
  assign op     = gate_op_e'(gate_sel);

  for (genvar i = 0; i < NUM_OPS; i++) begin : g_split
    nv_sym_split u_split (
      .sym  (ops[i]),
      .good (comp[i][0]),
      .bad  (comp[i][1])
    );
  end

  for (genvar m = 0; m < NUM_MACH; m++) begin : g_mach
    nv_trit_gate u_gate (
      .op (op),
      .a  (comp[0][m]),
      .b  (comp[1][m]),
      .y  (outc[m])
    );
  end

  nv_sym_join u_join (
    .good (outc[0]),
    .bad  (outc[1]),
    .sym  (sym_c),
    .fx   (fx_c),
    .kn   (kn_c)
  );

  if (REG_OUT) begin : g_reg
    sym_t res_q, res_d;
    logic fx_q, fx_d, kn_q, kn_d;

    always_comb begin
      res_d = res_q;
      fx_d  = fx_q;
      kn_d  = kn_q;
      if (en) begin
        res_d = sym_c;
        fx_d  = fx_c;
        kn_d  = kn_c;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        res_q <= S_XX;
        fx_q  <= 1'b0;
        kn_q  <= 1'b0;
      end else begin
        res_q <= res_d;
        fx_q  <= fx_d;
        kn_q  <= kn_d;
      end
    end

    assign res      = res_q;
    assign fault_fx = fx_q;
    assign known    = kn_q;
  end else begin : g_comb
    assign res      = sym_c;
    assign fault_fx = fx_c;
    assign known    = kn_c;
  end
endmodule

// File: rtl/nv_eval_chk.sv
`timescale 1ns/1ps
module nv_eval_chk #(
  parameter bit REG_OUT = 1'b1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic [3:0] op_a,
  input logic [3:0] op_b,
  input logic [2:0] gate_sel,
  input logic [3:0] res,
  input logic       fault_fx,
  input logic       known
);
  logic [3:0] c_a, c_b;
  logic [2:0] c_sel;
  logic       c_ok;
  logic       en_q, live;

  if (REG_OUT) begin : g_cap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        c_a <= 4'd0; c_b <= 4'd0; c_sel <= 3'd0; c_ok <= 1'b0;
      end else if (en) begin
        c_a <= op_a; c_b <= op_b; c_sel <= gate_sel; c_ok <= 1'b1;
      end
    end
  end else begin : g_dir
    assign c_a = op_a;
    assign c_b = op_b;
    assign c_sel = gate_sel;
    assign c_ok = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      live <= 1'b0;
    end else begin
      en_q <= en;
      live <= 1'b1;
    end
  end

  a_r1_code_range: assert property (@(posedge clk) disable iff (!rst_n)
    res <= 4'd8);
  a_r5_fault_flag: assert property (@(posedge clk) disable iff (!rst_n)
    fault_fx == (res == 4'd2 || res == 4'd3));
  a_r6_known_flag: assert property (@(posedge clk) disable iff (!rst_n)
    known == (res <= 4'd3));
  a_r2_and_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    (c_ok && c_sel == 3'd0 && (c_a == 4'd0 || c_b == 4'd0)) |-> res == 4'd0);
  a_r4_not_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (c_ok && c_sel == 3'd6 && c_a == 4'd2) |-> res == 4'd3);
  a_r4_buf_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (c_ok && c_sel == 3'd7 && c_a <= 4'd8) |-> res == c_a);
  a_r7_bad_code: assert property (@(posedge clk) disable iff (!rst_n)
    (c_ok && c_sel == 3'd7 && c_a > 4'd8) |-> res == 4'd4);
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (REG_OUT && live && !en_q) |-> $stable(res));
endmodule

bind nine_val_eval nv_eval_chk #(.REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/tb_nine_val_eval.sv
`timescale 1ns/1ps
module tb_nine_val_eval;
  logic clk, rst_n, en;
  logic [3:0] op_a, op_b;
  logic [2:0] gate_sel;
  logic [3:0] res_r, res_c;
  logic fx_r, fx_c, kn_r, kn_c;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  nine_val_eval #(.REG_OUT(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .op_a(op_a), .op_b(op_b),
    .gate_sel(gate_sel), .res(res_r), .fault_fx(fx_r), .known(kn_r));
  nine_val_eval #(.REG_OUT(1'b0)) dut_comb (
    .clk(clk), .rst_n(rst_n), .en(en), .op_a(op_a), .op_b(op_b),
    .gate_sel(gate_sel), .res(res_c), .fault_fx(fx_c), .known(kn_c));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // {gate_sel, op_a, op_b, expected}
  localparam int NV = 13;
  localparam logic [14:0] VEC [NV] = '{
    {3'd0, 4'd2, 4'd3, 4'd0},   // R2 AND D,Dbar
    {3'd0, 4'd2, 4'd1, 4'd2},   // R2 AND D,1
    {3'd1, 4'd2, 4'd3, 4'd1},   // R2 OR D,Dbar
    {3'd4, 4'd2, 4'd1, 4'd3},   // R3 XOR D,1
    {3'd5, 4'd2, 4'd2, 4'd1},   // R3 XNOR D,D
    {3'd2, 4'd5, 4'd4, 4'd6},   // R2 NAND G0,X
    {3'd3, 4'd8, 4'd0, 4'd7},   // R2 NOR F1,0
    {3'd0, 4'd6, 4'd8, 4'd4},   // R2 AND G1,F1
    {3'd6, 4'd5, 4'd0, 4'd6},   // R4 NOT G0
    {3'd6, 4'd2, 4'd1, 4'd3},   // R4 NOT D
    {3'd7, 4'd7, 4'd2, 4'd7},   // R4 BUF F0
    {3'd4, 4'd6, 4'd2, 4'd5},   // R3 XOR G1,D
    {3'd0, 4'd15, 4'd0, 4'd0}   // R7 AND invalid,0
  };

  // component values 0,1,2(=X)
  function automatic int gpart(input logic [3:0] s);
    case (s)
      4'd0, 4'd3, 4'd5: return 0;
      4'd1, 4'd2, 4'd6: return 1;
      default: return 2;
    endcase
  endfunction
  function automatic int fpart(input logic [3:0] s);
    case (s)
      4'd0, 4'd2, 4'd7: return 0;
      4'd1, 4'd3, 4'd8: return 1;
      default: return 2;
    endcase
  endfunction
  function automatic int inv3(input int v);
    return (v == 2) ? 2 : 1 - v;
  endfunction
  function automatic int gate3(input int sel, input int x, input int y);
    int r;
    case (sel)
      0, 2: r = (x == 0 || y == 0) ? 0 : (x == 1 && y == 1) ? 1 : 2;
      1, 3: r = (x == 1 || y == 1) ? 1 : (x == 0 && y == 0) ? 0 : 2;
      4, 5: r = (x == 2 || y == 2) ? 2 : (x ^ y);
      6:    r = inv3(x);
      default: r = x;
    endcase
    if (sel == 2 || sel == 3 || sel == 5) r = inv3(r);
    return r;
  endfunction
  function automatic logic [3:0] pack(input int g, input int f);
    if (g == 0 && f == 0) return 4'd0;
    if (g == 1 && f == 1) return 4'd1;
    if (g == 1 && f == 0) return 4'd2;
    if (g == 0 && f == 1) return 4'd3;
    if (g == 0) return 4'd5;
    if (g == 1) return 4'd6;
    if (f == 0) return 4'd7;
    if (f == 1) return 4'd8;
    return 4'd4;
  endfunction
  function automatic logic [3:0] ref_eval(input int sel, input logic [3:0] a,
                                          input logic [3:0] b);
    return pack(gate3(sel, gpart(a), gpart(b)), gate3(sel, fpart(a), fpart(b)));
  endfunction

  task automatic chk(input string req, input logic [3:0] r, input logic fx,
                     input logic kn, input logic [3:0] e);
    logic efx, ekn;
    efx = (e == 4'd2 || e == 4'd3);
    ekn = (e <= 4'd3);
    n_chk++;
    if (r !== e || fx !== efx || kn !== ekn) begin
      n_bad++;
      $display("FAIL %s sel=%0d a=%0d b=%0d: got res=%0d fx=%b kn=%b, expected res=%0d fx=%b kn=%b",
               req, gate_sel, op_a, op_b, r, fx, kn, e, efx, ekn);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  // apply one vector to both copies: combinational now, registered after the edge
  task automatic apply(input string req, input logic [2:0] s, input logic [3:0] a,
                       input logic [3:0] b, input logic [3:0] e);
    @(negedge clk);
    gate_sel = s; op_a = a; op_b = b; en = 1'b1;
    #1 chk({req, " comb"}, res_c, fx_c, kn_c, e);
    @(posedge clk);
    #1 chk({req, " reg R8"}, res_r, fx_r, kn_r, e);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_run();
  end

  initial begin
    logic [3:0] held;
    rst_n = 1'b0; en = 1'b0; op_a = 4'd1; op_b = 4'd1; gate_sel = 3'd0;
    repeat (3) @(posedge clk);
    #1 chk("R9 reset", res_r, fx_r, kn_r, 4'd4);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < NV; i++)
      apply("R1 table", VEC[i][14:12], VEC[i][11:8], VEC[i][7:4], VEC[i][3:0]);

    // exhaustive sweep: R2 R3 R4 R5 R6
    for (int s = 0; s < 8; s++)
      for (int a = 0; a < 9; a++)
        for (int b = 0; b < 9; b++)
          apply("R2/R3/R4 sweep", 3'(s), 4'(a), 4'(b), ref_eval(s, 4'(a), 4'(b)));

    // R7: unused codes behave as X/X
    for (int c = 9; c < 16; c++) begin
      apply("R7 or-one", 3'd1, 4'(c), 4'd1, 4'd1);
      apply("R7 buf", 3'd7, 4'(c), 4'd0, 4'd4);
    end

    // R4: op_b has no effect on NOT/BUF
    for (int b = 0; b < 16; b++) apply("R4 not-ignores-b", 3'd6, 4'd7, 4'(b), 4'd8);

    // R8: enable low holds the registered result
    apply("R8 load", 3'd0, 4'd2, 4'd1, 4'd2);
    held = res_r;
    @(negedge clk);
    en = 1'b0; gate_sel = 3'd1; op_a = 4'd1; op_b = 4'd0;
    repeat (2) @(posedge clk);
    #1 chk("R8 hold", res_r, fx_r, kn_r, held);
    chk("R8 comb follows", res_c, fx_c, kn_c, 4'd1);

    // R9: asynchronous reset mid-run, no clock edge needed
    apply("R9 preload", 3'd7, 4'd3, 4'd0, 4'd3);
    @(negedge clk);
    rst_n = 1'b0;
    #1 chk("R9 async", res_r, fx_r, kn_r, 4'd4);
    @(negedge clk) rst_n = 1'b1;
    apply("R9 recover", 3'd4, 4'd1, 4'd0, 4'd1);

    finish_run();
  end
endmodule